// File: doc/BRIEF.md
# ATA Task-File Register Bank

This block is the host-facing register front end of a storage bridge. To a host processor, the bridge looks like an ordinary ATA drive. The host reads and writes a bank of byte-wide shadow registers: sector count, the three address bytes, the device byte, features, status and command, plus one 16-bit data port. The block decodes each access from chip selects and address lines. The decode follows one of two bus conventions, picked by a static mode input. In the IDE convention there are two active-low selects and three address bits. In the memory-bus convention there is one active-low select and four address bits.

Accepted command codes go to an internal sequencer as a one-cycle pulse. The sequencer also receives the current parameter registers, shown as a 48-bit block address and a 16-bit count. The sequencer returns its busy, ready, fault, data-request and error flags and an error code. It can also raise an interrupt request.

The block keeps an internal interrupt-pending latch and drives the interrupt output with a polarity that depends on the mode. It also handles three device-control functions:
- the interrupt mask;
- the soft reset, which holds the bank busy and then asks the sequencer to restart;
- the high-order-byte selector, which exposes the previous contents of the count and address registers for 48-bit addressing.

Top module: `taskfile_regs`

## Requirements
- R1: In IDE mode (cpuMode=0), csN=2'b01 (csN[1] low, csN[0] high) selects the control block. Only address 3'b110 is implemented there: a read returns alternate status and a write loads device control. Every other control address reads 0 and ignores writes. csN=2'b11 or 2'b00 selects nothing and reads return 0.
- R2: In IDE mode, csN=2'b10 selects the command block, with the register chosen by addr[2:0]:
  - 0 = data
  - 1 = error on read, feature on write
  - 2 = sector count
  - 3 = address bits 7:0
  - 4 = address bits 15:8
  - 5 = address bits 23:16
  - 6 = device
  - 7 = status on read, command on write
- R3: In memory-bus mode (cpuMode=1), the block is selected only when csN[0] is low, and csN[1] is ignored. addr[3]=1 with addr[2:0]=3'b110 is the control register. addr[3]=0 selects the command block at the offsets given in R2.
- R4: The data register holds all 16 bits of a write. The other registers take wrData[7:0]; reading them returns 0 in bits 15:8.
- R5: The status byte is laid out as follows:
  - bit 7: busy, which is seqBusy OR soft reset
  - bit 6: seqDrdy
  - bit 5: seqDf
  - bit 3: seqDrq
  - bit 1: NOT devChgN
  - bit 0: seqErr
  - bits 4 and 2: read 0
- R6: A seqIntReq pulse sets the pending interrupt. A status read clears it. An alternate-status read returns the same byte and leaves it set.
- R7: An accepted command write produces, on the next cycle, seqCmdValid high for exactly one cycle with seqCmd equal to the written code. The same write clears the pending interrupt.
- R8: The interrupt output is active high and 0 out of reset when cpuMode=0. It is active low and 1 out of reset when cpuMode=1.
- R9: Device control bit 1 is the interrupt mask. While the mask is set, the output stays inactive but the pending latch still sets. Clearing the mask then shows the pending interrupt.
- R10: Count and each of the three address registers keep their previous byte when written. Device control bit 7 (HOB) makes reads return those previous bytes. Any accepted command-block write clears HOB. seqCount is {previous count, count}. seqLba is {previous high, previous mid, previous low, high, mid, low}.
- R11: Device control bit 2 is soft reset. While it is set:
  - busy reads 1;
  - the pending interrupt is cleared;
  - seqIntReq is ignored.
  A device-control write that takes it from 1 to 0 produces a one-cycle seqSoftReset pulse on the next cycle.
- R12: While busy is 1, writes to the command block (including the command register) are ignored. Device-control writes still take effect.
- R13: A read of the error register returns seqErrCode unchanged. Its abort flag is at bit 2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| cpuMode | input | 1 | 0 = IDE decode, 1 = memory-bus decode (static) |
| csN | input | 2 | Active-low chip selects |
| addr | input | 4 | Register address (IDE uses bits 2:0) |
| rdStb | input | 1 | One-cycle read strobe |
| wrStb | input | 1 | One-cycle write strobe |
| wrData | input | 16 | Write data |
| rdData | output | 16 | Read data, valid while rdStb is high |
| intrq | output | 1 | Interrupt request, polarity per R8 |
| seqIntReq | input | 1 | Sequencer interrupt request pulse |
| seqBusy | input | 1 | Sequencer busy flag |
| seqDrdy | input | 1 | Sequencer ready flag |
| seqDf | input | 1 | Sequencer fault flag |
| seqDrq | input | 1 | Sequencer data-request flag |
| seqErr | input | 1 | Sequencer error flag |
| seqErrCode | input | 8 | Error register contents |
| devChgN | input | 1 | Active-low device-change indication |
| seqCmdValid | output | 1 | One-cycle command handoff pulse |
| seqCmd | output | 8 | Command code |
| seqSoftReset | output | 1 | One-cycle soft-reset request |
| seqFeature | output | 8 | Feature byte |
| seqDevice | output | 8 | Device byte |
| seqCount | output | 16 | Previous and current sector count |
| seqLba | output | 48 | Previous and current address bytes |
| seqData | output | 16 | Last written data word |

## Verification
The hardest situations to reach from the ports are those where the pending latch and the visible output disagree. One is an interrupt raised while the mask is set. The other is a request arriving during soft reset. The stimulus writes device control to set the mask or the reset bit and then pulses seqIntReq. It then checks that the output stays inactive. Next it clears the control bit and checks that the latched interrupt appears in the masked case and is gone in the reset case. A write made under busy is checked the same way: the register is read back after busy drops.

// File: rtl/tfr_pkg.sv
package tfr_pkg;

  typedef enum logic [3:0] {
    RS_NONE, RS_DATA, RS_ERR, RS_COUNT, RS_LBALO,
    RS_LBAMID, RS_LBAHI, RS_DEV, RS_STATUS, RS_ALT
  } rdSel_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic   wrData;
    logic   wrFeature;
    logic   wrCount;
    logic   wrLbaLo;
    logic   wrLbaMid;
    logic   wrLbaHi;
    logic   wrDevice;
    logic   wrCmd;
    rdSel_e rdSel;
    logic   hob;
  } tfrStrobe_t;

endpackage

// File: rtl/tfr_ctrl.sv
module tfr_ctrl
  import tfr_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int REG_W  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cpuMode,
  input  logic [1:0]        csN,
  input  logic [ADDR_W-1:0] addr,
  input  logic              rdStb,
  input  logic              wrStb,
  input  logic [REG_W-1:0]  wrByte,
  input  logic              seqIntReq,
  input  logic              seqBusy,
  input  logic              seqDrdy,
  input  logic              seqDf,
  input  logic              seqDrq,
  input  logic              seqErr,
  input  logic              devChgN,
  output tfrStrobe_t        strb,
  output logic [REG_W-1:0]  statusByte,
  output logic              intrq,
  output logic              nIenQ,
  output logic              srstQ,
  output logic              seqCmdValid,
  output logic [REG_W-1:0]  seqCmd,
  output logic              seqSoftReset
);

  localparam logic [2:0] CTRL_OFF = 3'b110;

  logic       ctlHit, cmdHit, bsy, cmdWrOk, devCtlWr, statusRd;
  logic [2:0] off;
  logic       hobQ, pendQ;

  assign off = addr[2:0];

  // Bus decode, variant chosen by mode
  always_comb begin
    ctlHit = 1'b0;
    cmdHit = 1'b0;
    if (cpuMode) begin
      if (!csN[0]) begin
        if (addr[ADDR_W-1]) ctlHit = (off == CTRL_OFF);
        else                cmdHit = 1'b1;
      end
    end else begin
      if (!csN[1] && csN[0]) ctlHit = (off == CTRL_OFF);
      if (csN[1] && !csN[0]) cmdHit = 1'b1;
    end
  end

  assign bsy      = seqBusy | srstQ;
  assign cmdWrOk  = wrStb & cmdHit & ~bsy;
  assign devCtlWr = wrStb & ctlHit;
  assign statusRd = rdStb & cmdHit & (off == 3'd7);

  always_comb begin
    strb           = '0;
    strb.hob       = hobQ;
    strb.rdSel     = RS_NONE;
    strb.wrData    = cmdWrOk & (off == 3'd0);
    strb.wrFeature = cmdWrOk & (off == 3'd1);
    strb.wrCount   = cmdWrOk & (off == 3'd2);
    strb.wrLbaLo   = cmdWrOk & (off == 3'd3);
    strb.wrLbaMid  = cmdWrOk & (off == 3'd4);
    strb.wrLbaHi   = cmdWrOk & (off == 3'd5);
    strb.wrDevice  = cmdWrOk & (off == 3'd6);
    strb.wrCmd     = cmdWrOk & (off == 3'd7);
    if (rdStb && ctlHit) strb.rdSel = RS_ALT;
    else if (rdStb && cmdHit) begin
      case (off)
        3'd0:    strb.rdSel = RS_DATA;
        3'd1:    strb.rdSel = RS_ERR;
        3'd2:    strb.rdSel = RS_COUNT;
        3'd3:    strb.rdSel = RS_LBALO;
        3'd4:    strb.rdSel = RS_LBAMID;
        3'd5:    strb.rdSel = RS_LBAHI;
        3'd6:    strb.rdSel = RS_DEV;
        default: strb.rdSel = RS_STATUS;
      endcase
    end
  end

  assign statusByte = {bsy, seqDrdy, seqDf, 1'b0, seqDrq, 1'b0, ~devChgN, seqErr};

  // Device control, interrupt latch and sequencer handoff
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hobQ         <= 1'b0;
      nIenQ        <= 1'b0;
      srstQ        <= 1'b0;
      pendQ        <= 1'b0;
      seqCmdValid  <= 1'b0;
      seqCmd       <= '0;
      seqSoftReset <= 1'b0;
    end else begin
      seqSoftReset <= devCtlWr & srstQ & ~wrByte[2];
      seqCmdValid  <= strb.wrCmd;
      if (strb.wrCmd) seqCmd <= wrByte;
      if (devCtlWr) begin
        hobQ  <= wrByte[REG_W-1];
        srstQ <= wrByte[2];
        nIenQ <= wrByte[1];
      end else if (cmdWrOk) begin
        hobQ <= 1'b0;
      end
      if (srstQ)                      pendQ <= 1'b0;
      else if (seqIntReq)             pendQ <= 1'b1;
      else if (statusRd || strb.wrCmd) pendQ <= 1'b0;
    end
  end

  assign intrq = cpuMode ^ (pendQ & ~nIenQ);

endmodule

// File: rtl/tfr_datapath.sv
module tfr_datapath
  import tfr_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int REG_W  = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  tfrStrobe_t          strb,
  input  logic [DATA_W-1:0]   wrData,
  input  logic [REG_W-1:0]    statusByte,
  input  logic [REG_W-1:0]    seqErrCode,
  output logic [DATA_W-1:0]   rdData,
  output logic [REG_W-1:0]    seqFeature,
  output logic [REG_W-1:0]    seqDevice,
  output logic [2*REG_W-1:0]  seqCount,
  output logic [6*REG_W-1:0]  seqLba,
  output logic [DATA_W-1:0]   seqData
);

  localparam int NSH = 4;              // count, low, mid, high
  localparam int PAD = DATA_W - REG_W;

  logic [NSH-1:0]    shWe;
  logic [REG_W-1:0]  curB  [NSH];
  logic [REG_W-1:0]  prevB [NSH];
  logic [REG_W-1:0]  shRd  [NSH];

  assign shWe = {strb.wrLbaHi, strb.wrLbaMid, strb.wrLbaLo, strb.wrCount};

  for (genvar i = 0; i < NSH; i++) begin : g_shadow
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        curB[i]  <= '0;
        prevB[i] <= '0;
      end else if (shWe[i]) begin
        prevB[i] <= curB[i];
        curB[i]  <= wrData[REG_W-1:0];
      end
    end
    assign shRd[i] = strb.hob ? prevB[i] : curB[i];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      seqData    <= '0;
      seqFeature <= '0;
      seqDevice  <= '0;
    end else begin
      if (strb.wrData)    seqData    <= wrData;
      if (strb.wrFeature) seqFeature <= wrData[REG_W-1:0];
      if (strb.wrDevice)  seqDevice  <= wrData[REG_W-1:0];
    end
  end

  always_comb begin
    rdData = '0;
    case (strb.rdSel)
      RS_DATA:             rdData = seqData;
      RS_ERR:              rdData = {{PAD{1'b0}}, seqErrCode};
      RS_COUNT:            rdData = {{PAD{1'b0}}, shRd[0]};
      RS_LBALO:            rdData = {{PAD{1'b0}}, shRd[1]};
      RS_LBAMID:           rdData = {{PAD{1'b0}}, shRd[2]};
      RS_LBAHI:            rdData = {{PAD{1'b0}}, shRd[3]};
      RS_DEV:              rdData = {{PAD{1'b0}}, seqDevice};
      RS_STATUS, RS_ALT:   rdData = {{PAD{1'b0}}, statusByte};
      default:             rdData = '0;
    endcase
  end

  assign seqCount = {prevB[0], curB[0]};
  assign seqLba   = {prevB[3], prevB[2], prevB[1], curB[3], curB[2], curB[1]};

endmodule

// File: rtl/taskfile_regs.sv
module taskfile_regs
  import tfr_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int REG_W  = 8,
  parameter int ADDR_W = 4
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                cpuMode,
  input  logic [1:0]          csN,
  input  logic [ADDR_W-1:0]   addr,
  input  logic                rdStb,
  input  logic                wrStb,
  input  logic [DATA_W-1:0]   wrData,
  output logic [DATA_W-1:0]   rdData,
  output logic                intrq,
  input  logic                seqIntReq,
  input  logic                seqBusy,
  input  logic                seqDrdy,
  input  logic                seqDf,
  input  logic                seqDrq,
  input  logic                seqErr,
  input  logic [REG_W-1:0]    seqErrCode,
  input  logic                devChgN,
  output logic                seqCmdValid,
  output logic [REG_W-1:0]    seqCmd,
  output logic                seqSoftReset,
  output logic [REG_W-1:0]    seqFeature,
  output logic [REG_W-1:0]    seqDevice,
  output logic [2*REG_W-1:0]  seqCount,
  output logic [6*REG_W-1:0]  seqLba,
  output logic [DATA_W-1:0]   seqData
);

  tfrStrobe_t       strb;
  logic [REG_W-1:0] statusByte;
  logic             nIenQ, srstQ;

  tfr_ctrl #(.ADDR_W(ADDR_W), .REG_W(REG_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .cpuMode(cpuMode), .csN(csN), .addr(addr),
    .rdStb(rdStb), .wrStb(wrStb), .wrByte(wrData[REG_W-1:0]),
    .seqIntReq(seqIntReq), .seqBusy(seqBusy), .seqDrdy(seqDrdy),
    .seqDf(seqDf), .seqDrq(seqDrq), .seqErr(seqErr), .devChgN(devChgN),
    .strb(strb), .statusByte(statusByte), .intrq(intrq),
    .nIenQ(nIenQ), .srstQ(srstQ), .seqCmdValid(seqCmdValid),
    .seqCmd(seqCmd), .seqSoftReset(seqSoftReset)
  );

  tfr_datapath #(.DATA_W(DATA_W), .REG_W(REG_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .wrData(wrData),
    .statusByte(statusByte), .seqErrCode(seqErrCode), .rdData(rdData),
    .seqFeature(seqFeature), .seqDevice(seqDevice), .seqCount(seqCount),
    .seqLba(seqLba), .seqData(seqData)
  );

endmodule

// File: rtl/taskfile_regs_chk.sv
module taskfile_regs_chk
  import tfr_pkg::*;
#(
  parameter int REG_W = 8
) (
  input logic             clk,
  input logic             rstN,
  input logic             cpuMode,
  input logic             wrStb,
  input logic [REG_W-1:0] wrByte,
  input tfrStrobe_t       strb,
  input logic [REG_W-1:0] statusByte,
  input logic             intrq,
  input logic             seqIntReq,
  input logic             nIenQ,
  input logic             srstQ,
  input logic             seqCmdValid,
  input logic [REG_W-1:0] seqCmd,
  input logic             seqSoftReset
);

  // R6: status read drops the request
  p_status_clears_r6: assert property (@(posedge clk) disable iff (!rstN)
    (strb.rdSel == RS_STATUS && !seqIntReq) |=> (intrq == cpuMode));

  // R6: alternate status read leaves the request alone
  p_alt_keeps_r6: assert property (@(posedge clk) disable iff (!rstN)
    (strb.rdSel == RS_ALT && !wrStb && !seqIntReq && !srstQ) |=> $stable(intrq));

  // R7: command handoff one cycle later with the written code
  p_cmd_handoff_r7: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrCmd |=> (seqCmdValid && seqCmd == $past(wrByte)));

  // R9: mask keeps the output inactive
  p_mask_inactive_r9: assert property (@(posedge clk) disable iff (!rstN)
    nIenQ |-> (intrq == cpuMode));

  // R11: soft reset reads busy
  p_srst_busy_r11: assert property (@(posedge clk) disable iff (!rstN)
    srstQ |-> statusByte[REG_W-1]);

  // R11: restart request follows release of soft reset
  p_srst_pulse_r11: assert property (@(posedge clk) disable iff (!rstN)
    seqSoftReset |-> (!srstQ && $past(srstQ)));

  // R12: no command-block write is accepted while busy
  p_busy_blocks_r12: assert property (@(posedge clk) disable iff (!rstN)
    statusByte[REG_W-1] |-> !(strb.wrCmd || strb.wrCount || strb.wrLbaLo));

endmodule

bind taskfile_regs taskfile_regs_chk #(.REG_W(REG_W)) u_chk (
  .clk(clk), .rstN(rstN), .cpuMode(cpuMode), .wrStb(wrStb),
  .wrByte(wrData[REG_W-1:0]), .strb(strb), .statusByte(statusByte),
  .intrq(intrq), .seqIntReq(seqIntReq), .nIenQ(nIenQ), .srstQ(srstQ),
  .seqCmdValid(seqCmdValid), .seqCmd(seqCmd), .seqSoftReset(seqSoftReset)
);

// File: tb/taskfile_regs_tb.sv
`timescale 1ns/1ps
module taskfile_regs_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cpuMode = 1'b0;
  logic [1:0]  csN = 2'b11;
  logic [3:0]  addr = '0;
  logic        rdStb = 1'b0, wrStb = 1'b0;
  logic [15:0] wrData = '0;
  logic [15:0] rdData;
  logic        intrq;
  logic        seqIntReq = 1'b0, seqBusy = 1'b0, seqDrdy = 1'b1;
  logic        seqDf = 1'b0, seqDrq = 1'b0, seqErr = 1'b0;
  logic [7:0]  seqErrCode = 8'h04;
  logic        devChgN = 1'b1;
  logic        seqCmdValid, seqSoftReset;
  logic [7:0]  seqCmd, seqFeature, seqDevice;
  logic [15:0] seqCount, seqData;
  logic [47:0] seqLba;

  int total = 0;
  int bad = 0;

  always #2 clk = ~clk;  // 250 MHz

  taskfile_regs u_dut (
    .clk(clk), .rstN(rstN), .cpuMode(cpuMode), .csN(csN), .addr(addr),
    .rdStb(rdStb), .wrStb(wrStb), .wrData(wrData), .rdData(rdData),
    .intrq(intrq), .seqIntReq(seqIntReq), .seqBusy(seqBusy),
    .seqDrdy(seqDrdy), .seqDf(seqDf), .seqDrq(seqDrq), .seqErr(seqErr),
    .seqErrCode(seqErrCode), .devChgN(devChgN), .seqCmdValid(seqCmdValid),
    .seqCmd(seqCmd), .seqSoftReset(seqSoftReset), .seqFeature(seqFeature),
    .seqDevice(seqDevice), .seqCount(seqCount), .seqLba(seqLba),
    .seqData(seqData)
  );

  localparam logic [1:0] CMD = 2'b10;
  localparam logic [1:0] CTL = 2'b01;

  // {write, csN, addr, data, expected read}
  localparam int NV = 23;
  localparam logic [38:0] VEC [NV] = '{
    {1'b1, CMD,   4'd2, 16'h0005, 16'h0000},
    {1'b1, CMD,   4'd3, 16'h0011, 16'h0000},
    {1'b1, CMD,   4'd3, 16'h0022, 16'h0000},
    {1'b1, CMD,   4'd4, 16'h0033, 16'h0000},
    {1'b1, CMD,   4'd5, 16'h0044, 16'h0000},
    {1'b1, CMD,   4'd6, 16'h00E0, 16'h0000},
    {1'b0, CMD,   4'd2, 16'h0000, 16'h0005},
    {1'b0, CMD,   4'd3, 16'h0000, 16'h0022},
    {1'b0, CMD,   4'd6, 16'h0000, 16'h00E0},
    {1'b1, CTL,   4'd6, 16'h0080, 16'h0000},
    {1'b0, CMD,   4'd3, 16'h0000, 16'h0011},
    {1'b0, CMD,   4'd2, 16'h0000, 16'h0000},
    {1'b0, CMD,   4'd4, 16'h0000, 16'h0000},
    {1'b1, CMD,   4'd0, 16'hBEEF, 16'h0000},
    {1'b0, CMD,   4'd0, 16'h0000, 16'hBEEF},
    {1'b0, CMD,   4'd3, 16'h0000, 16'h0022},
    {1'b0, CTL,   4'd5, 16'h0000, 16'h0000},
    {1'b0, CMD,   4'd7, 16'h0000, 16'h0040},
    {1'b0, CTL,   4'd6, 16'h0000, 16'h0040},
    {1'b0, CMD,   4'd1, 16'h0000, 16'h0004},
    {1'b1, CMD,   4'd2, 16'h1234, 16'h0000},
    {1'b0, CMD,   4'd2, 16'h0000, 16'h0034},
    {1'b0, 2'b00, 4'd2, 16'h0000, 16'h0000}
  };

  function automatic string vecTag(int i);
    case (i)
      9, 10, 11, 12, 15: return "R10 high-order bytes";
      14:                return "R4 data word";
      16:                return "R1 unimplemented control";
      17:                return "R5 status";
      18:                return "R6 alternate status";
      19:                return "R13 error code";
      21:                return "R4 byte width";
      22:                return "R1 no select";
      default:           return "R2 command block";
    endcase
  endfunction

  task automatic check(input string tag, input logic [47:0] act, input logic [47:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic busWr(input logic [1:0] cs, input logic [3:0] a, input logic [15:0] d);
    @(negedge clk);
    csN = cs; addr = a; wrData = d; wrStb = 1'b1;
    @(negedge clk);
    wrStb = 1'b0; csN = 2'b11;
  endtask

  task automatic busRd(input logic [1:0] cs, input logic [3:0] a, output logic [15:0] d);
    @(negedge clk);
    csN = cs; addr = a; rdStb = 1'b1;
    #1 d = rdData;
    @(negedge clk);
    rdStb = 1'b0; csN = 2'b11;
  endtask

  task automatic pulseInt();
    @(negedge clk);
    seqIntReq = 1'b1;
    @(negedge clk);
    seqIntReq = 1'b0;
  endtask

  task automatic doReset();
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog act=running exp=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : main
    logic [15:0] rd;
    doReset();
    check("R8 IDE intrq reset low", 48'(intrq), 48'd0);
    check("R7 no command at reset", 48'(seqCmdValid), 48'd0);
    check("R11 no soft reset at reset", 48'(seqSoftReset), 48'd0);

    for (int i = 0; i < NV; i++) begin
      if (VEC[i][38]) busWr(VEC[i][37:36], VEC[i][35:32], VEC[i][31:16]);
      else begin
        busRd(VEC[i][37:36], VEC[i][35:32], rd);
        check(vecTag(i), 48'(rd), 48'(VEC[i][15:0]));
      end
    end
    check("R10 seqLba", seqLba, 48'h0000_1144_3322);
    check("R10 seqCount", 48'(seqCount), 48'h0534);

    // R7 command handoff
    busWr(CMD, 4'd7, 16'h00EC);
    check("R7 cmd valid", 48'(seqCmdValid), 48'd1);
    check("R7 cmd code", 48'(seqCmd), 48'hEC);
    @(negedge clk);
    check("R7 single pulse", 48'(seqCmdValid), 48'd0);

    // R6 interrupt clear paths
    pulseInt();
    check("R6 intrq set", 48'(intrq), 48'd1);
    busRd(CTL, 4'd6, rd);
    check("R6 alt keeps intrq", 48'(intrq), 48'd1);
    busRd(CMD, 4'd7, rd);
    check("R6 status clears intrq", 48'(intrq), 48'd0);
    pulseInt();
    busWr(CMD, 4'd7, 16'h0020);
    check("R7 command clears intrq", 48'(intrq), 48'd0);

    // R9 mask
    busWr(CTL, 4'd6, 16'h0002);
    pulseInt();
    check("R9 masked intrq", 48'(intrq), 48'd0);
    busWr(CTL, 4'd6, 16'h0000);
    check("R9 pending shows after unmask", 48'(intrq), 48'd1);
    busRd(CMD, 4'd7, rd);

    // R1 unimplemented control write does not touch the mask
    busWr(CTL, 4'd2, 16'h0002);
    pulseInt();
    check("R1 control addr 2 ignored", 48'(intrq), 48'd1);
    busRd(CMD, 4'd7, rd);

    // R5 device change flag
    devChgN = 1'b0;
    busRd(CMD, 4'd7, rd);
    check("R5 change bit", 48'(rd), 48'h0042);
    devChgN = 1'b1;

    // R12 writes ignored while sequencer busy
    seqBusy = 1'b1;
    busRd(CMD, 4'd7, rd);
    check("R5 busy bit", 48'(rd), 48'h00C0);
    busWr(CMD, 4'd2, 16'h0077);
    busWr(CMD, 4'd7, 16'h0030);
    check("R12 cmd ignored while busy", 48'(seqCmdValid), 48'd0);
    seqBusy = 1'b0;
    busRd(CMD, 4'd2, rd);
    check("R12 count kept while busy", 48'(rd), 48'h0034);

    // R11 soft reset
    pulseInt();
    busWr(CTL, 4'd6, 16'h0004);
    @(negedge clk);
    check("R11 pending cleared", 48'(intrq), 48'd0);
    busRd(CTL, 4'd6, rd);
    check("R11 busy during reset", 48'(rd), 48'h00C0);
    busWr(CMD, 4'd2, 16'h0099);
    pulseInt();
    check("R11 request ignored", 48'(intrq), 48'd0);
    busWr(CTL, 4'd6, 16'h0000);
    check("R11 restart pulse", 48'(seqSoftReset), 48'd1);
    @(negedge clk);
    check("R11 pulse one cycle", 48'(seqSoftReset), 48'd0);
    busRd(CMD, 4'd2, rd);
    check("R12 count kept during reset", 48'(rd), 48'h0034);
    check("R11 no late interrupt", 48'(intrq), 48'd0);

    // Memory-bus mode
    cpuMode = 1'b1;
    doReset();
    check("R8 CPU intrq reset high", 48'(intrq), 48'd1);
    busWr(2'b10, 4'b0011, 16'h005A);
    busRd(2'b10, 4'b0011, rd);
    check("R3 CPU command block", 48'(rd), 48'h005A);
    busRd(2'b01, 4'b0011, rd);
    check("R3 CPU deselected", 48'(rd), 48'h0000);
    busRd(2'b00, 4'b1110, rd);
    check("R3 CPU control register", 48'(rd), 48'h0040);
    pulseInt();
    check("R8 CPU intrq active low", 48'(intrq), 48'd0);
    busRd(2'b10, 4'b0111, rd);
    check("R6 CPU status clears", 48'(intrq), 48'd1);
    busWr(2'b10, 4'b1110, 16'h0080);
    busRd(2'b10, 4'b0011, rd);
    check("R10 CPU previous byte", 48'(rd), 48'h0000);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule